// File: doc/BRIEF.md
# Process-Tagged Address Translation Cache

This block keeps up to eight recent virtual-page to physical-frame translations so that most memory accesses skip a full page-table walk. Every stored translation carries the identifier of the process that owns it. A requester presents a virtual page number together with the current process identifier. A translation owned by another process can never answer the request, so entries survive a context switch and need no flush.

When a lookup finds a stored translation, the frame number comes back in the same cycle. When it does not, the block stops taking new lookups and asks an external table walker for the missing page. If the walker reports a mapping, the block writes it into an entry and the requester retries, which then hits. If the walker reports no mapping, nothing is written and a one-cycle fault pulse goes back to the requester. Software can drop every translation in one cycle, or only the translations that belong to one process.

Top module: `xlat_cache`

## Requirements
- R1: With `lk_valid` high and `lk_ready` high, `lk_hit` is high in that same cycle exactly when a valid entry holds both the presented page number and the presented process identifier, and `lk_pfn` then carries that entry's frame number.
- R2: An entry whose page number matches but whose process identifier differs does not hit.
- R3: A lookup that misses while `lk_ready` is high raises `walk_req` from the next cycle on, with `walk_vpn`/`walk_pid` equal to the missed lookup and held steady. `lk_ready` stays low and `lk_hit` stays low until the cycle after `walk_done`.
- R4: When `walk_done` and `walk_ok` are both high, the returned frame is installed, and a lookup of the same page and process hits from the next cycle on.
- R5: When `walk_done` is high with `walk_ok` low, `lk_fault` is high for that one cycle, nothing is installed, and `lk_ready` returns the cycle after.
- R6: A refill writes the lowest-indexed invalid entry when one exists, and then the replacement pointer does not move.
- R7: When all entries are valid, a refill replaces the entry at a round-robin pointer. The pointer starts at index 0 after reset and advances by one, wrapping, after each such replacement.
- R8: `flush_all` clears every entry within one cycle, so no lookup hits in the following cycle.
- R9: `flush_one` clears only the entries whose process identifier equals `flush_pid`. Entries of other processes keep hitting.
- R10: A refill that completes in the same cycle as `flush_all`, or as `flush_one` for the walked process, is discarded without a fault.
- R11: After reset no entry is valid, `lk_ready` is high, and `walk_req` and `lk_fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup presented this cycle |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_pid | input | PID_W | Process identifier of the lookup |
| lk_ready | output | 1 | Block accepts lookups (no walk pending) |
| lk_hit | output | 1 | Lookup found a translation this cycle |
| lk_pfn | output | PFN_W | Frame number on a hit, zero otherwise |
| lk_fault | output | 1 | One-cycle page-fault pulse after a failed walk |
| walk_req | output | 1 | Walk requested for the pending page |
| walk_vpn | output | VPN_W | Page number to walk |
| walk_pid | output | PID_W | Process identifier of the walk |
| walk_done | input | 1 | Walker finished this cycle |
| walk_ok | input | 1 | Walker found a mapping |
| walk_pfn | input | PFN_W | Frame number found by the walker |
| flush_all | input | 1 | Invalidate every entry |
| flush_one | input | 1 | Invalidate entries of one process |
| flush_pid | input | PID_W | Process whose entries `flush_one` clears |

## Verification
Some properties are checked on every clock. At most one entry may match a lookup. No hit may appear while a walk is pending. A miss must raise the walk request, and the walk request must hold its page and process until the walker answers. A fault must hand control back to the requester. A full flush must leave no matching entry, and a successful refill must make the same lookup hit on the next cycle. Other behaviour only the bench scenarios can show, because it depends on a long history: which slot a refill overwrites (lowest free slot against round-robin order), whether a per-process flush spares other processes, and whether a refill that collides with a flush is dropped. The bench finds these by later lookups that hit or miss.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;
   typedef enum logic {
      ST_LOOK = 1'b0,
      ST_WALK = 1'b1
   } xlat_st_e;
endpackage

// File: rtl/xlat_match.sv
`timescale 1ns/1ps
// Parallel comparison of one lookup against every stored translation.
module xlat_match #(
   parameter int unsigned N     = 8,
   parameter int unsigned VPN_W = 20,
   parameter int unsigned PID_W = 8,
   parameter int unsigned PFN_W = 20
) (
   input  logic [N-1:0]            valid,
   input  logic [N-1:0][VPN_W-1:0] vpn_arr,
   input  logic [N-1:0][PID_W-1:0] pid_arr,
   input  logic [N-1:0][PFN_W-1:0] pfn_arr,
   input  logic [VPN_W-1:0]        q_vpn,
   input  logic [PID_W-1:0]        q_pid,
   output logic [N-1:0]            hit_vec,
   output logic                    any_hit,
   output logic [PFN_W-1:0]        hit_pfn
);
   for (genvar g = 0; g < N; g++) begin : g_cmp
      assign hit_vec[g] = valid[g] && (vpn_arr[g] == q_vpn) && (pid_arr[g] == q_pid);
   end

   assign any_hit = |hit_vec;

   always_comb begin
      hit_pfn = '0;
      for (int i = 0; i < N; i++) begin
         if (hit_vec[i]) hit_pfn = hit_pfn | pfn_arr[i];
      end
   end
endmodule

// File: rtl/xlat_victim.sv
`timescale 1ns/1ps
// Picks the slot a refill writes: lowest free slot, else round-robin pointer.
module xlat_victim #(
   parameter int unsigned N     = 8,
   parameter int unsigned IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     valid,
   input  logic             fill_go,
   output logic [IDX_W-1:0] slot,
   output logic             full
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

   logic [IDX_W-1:0] rr_q;
   logic [IDX_W-1:0] rr_next;

   assign full = &valid;

   always_comb begin
      slot = rr_q;
      for (int i = N - 1; i >= 0; i--) begin
         if (!valid[i]) slot = IDX_W'(i);
      end
   end

   if ((N & (N - 1)) == 0) begin : g_pow2_wrap
      assign rr_next = rr_q + 1'b1;
   end else begin : g_cmp_wrap
      assign rr_next = (rr_q == LAST) ? '0 : rr_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)              rr_q <= '0;
      else if (fill_go && full) rr_q <= rr_next;
   end
endmodule

// File: rtl/xlat_cache.sv
`timescale 1ns/1ps
// Process-tagged, fully associative translation cache with walker hand-off.
module xlat_cache #(
   parameter int unsigned ENTRIES = 8,
   parameter int unsigned VPN_W   = 20,
   parameter int unsigned PFN_W   = 20,
   parameter int unsigned PID_W   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_valid,
   input  logic [VPN_W-1:0] lk_vpn,
   input  logic [PID_W-1:0] lk_pid,
   output logic             lk_ready,
   output logic             lk_hit,
   output logic [PFN_W-1:0] lk_pfn,
   output logic             lk_fault,
   output logic             walk_req,
   output logic [VPN_W-1:0] walk_vpn,
   output logic [PID_W-1:0] walk_pid,
   input  logic             walk_done,
   input  logic             walk_ok,
   input  logic [PFN_W-1:0] walk_pfn,
   input  logic             flush_all,
   input  logic             flush_one,
   input  logic [PID_W-1:0] flush_pid
);
   import xlat_pkg::*;

   localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   if (ENTRIES < 2 || ENTRIES > 64) begin : g_bad_entries
      $error("xlat_cache: ENTRIES must lie in 2..64");
   end
   if (VPN_W < 1 || PFN_W < 1 || PID_W < 1) begin : g_bad_width
      $error("xlat_cache: field widths must be positive");
   end

   logic [ENTRIES-1:0]            ent_valid;
   logic [ENTRIES-1:0][VPN_W-1:0] ent_vpn;
   logic [ENTRIES-1:0][PID_W-1:0] ent_pid;
   logic [ENTRIES-1:0][PFN_W-1:0] ent_pfn;

   xlat_st_e         st_q;
   logic [VPN_W-1:0] pend_vpn;
   logic [PID_W-1:0] pend_pid;

   logic [ENTRIES-1:0] hit_vec;
   logic               any_hit;
   logic [PFN_W-1:0]   hit_pfn;
   logic [IDX_W-1:0]   fill_slot;
   logic               all_full;
   logic               walk_fin;
   logic               drop_fill;
   logic               do_fill;

   xlat_match #(
      .N(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W), .PFN_W(PFN_W)
   ) u_match (
      .valid   (ent_valid),
      .vpn_arr (ent_vpn),
      .pid_arr (ent_pid),
      .pfn_arr (ent_pfn),
      .q_vpn   (lk_vpn),
      .q_pid   (lk_pid),
      .hit_vec (hit_vec),
      .any_hit (any_hit),
      .hit_pfn (hit_pfn)
   );

   xlat_victim #(
      .N(ENTRIES), .IDX_W(IDX_W)
   ) u_victim (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid   (ent_valid),
      .fill_go (do_fill),
      .slot    (fill_slot),
      .full    (all_full)
   );

   assign lk_ready  = (st_q == ST_LOOK);
   assign lk_hit    = lk_valid && lk_ready && any_hit;
   assign lk_pfn    = lk_hit ? hit_pfn : '0;
   assign walk_req  = (st_q == ST_WALK);
   assign walk_vpn  = pend_vpn;
   assign walk_pid  = pend_pid;
   assign walk_fin  = walk_req && walk_done;
   assign lk_fault  = walk_fin && !walk_ok;
   assign drop_fill = flush_all || (flush_one && (flush_pid == pend_pid));
   assign do_fill   = walk_fin && walk_ok && !drop_fill;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_LOOK;
         pend_vpn <= '0;
         pend_pid <= '0;
      end else begin
         unique case (st_q)
            ST_LOOK: if (lk_valid && !any_hit) begin
               st_q     <= ST_WALK;
               pend_vpn <= lk_vpn;
               pend_pid <= lk_pid;
            end
            ST_WALK: if (walk_done) st_q <= ST_LOOK;
            default: st_q <= ST_LOOK;
         endcase
      end
   end

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_valid[e] <= 1'b0;
            ent_vpn[e]   <= '0;
            ent_pid[e]   <= '0;
            ent_pfn[e]   <= '0;
         end else if (do_fill && (fill_slot == IDX_W'(e))) begin
            ent_valid[e] <= 1'b1;
            ent_vpn[e]   <= pend_vpn;
            ent_pid[e]   <= pend_pid;
            ent_pfn[e]   <= walk_pfn;
         end else if (flush_all || (flush_one && (ent_pid[e] == flush_pid))) begin
            ent_valid[e] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/xlat_cache_chk.sv
`timescale 1ns/1ps
module xlat_cache_chk #(
   parameter int unsigned ENTRIES = 8,
   parameter int unsigned VPN_W   = 20,
   parameter int unsigned PFN_W   = 20,
   parameter int unsigned PID_W   = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               lk_valid,
   input logic [VPN_W-1:0]   lk_vpn,
   input logic [PID_W-1:0]   lk_pid,
   input logic               lk_ready,
   input logic               lk_hit,
   input logic               lk_fault,
   input logic               walk_req,
   input logic [VPN_W-1:0]   walk_vpn,
   input logic [PID_W-1:0]   walk_pid,
   input logic               walk_done,
   input logic               walk_ok,
   input logic               flush_all,
   input logic               flush_one,
   input logic [ENTRIES-1:0] hit_vec
);
   AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec)); // R1
   AST_NO_HIT_WHILE_WALK: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_ready |-> !lk_hit); // R3
   AST_MISS_STARTS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_ready && !lk_hit) |=> walk_req); // R3
   AST_WALK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_req && !walk_done) |=> (walk_req && $stable(walk_vpn) && $stable(walk_pid))); // R3
   AST_FAULT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      lk_fault |=> (lk_ready && !walk_req && !lk_fault)); // R5
   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush_all |=> (hit_vec == '0)); // R8
   AST_REFILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_req && walk_done && walk_ok && !flush_all && !flush_one)
      |=> (!(lk_valid && lk_vpn == $past(walk_vpn) && lk_pid == $past(walk_pid)) || lk_hit)); // R4
endmodule

bind xlat_cache xlat_cache_chk #(
   .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .PID_W(PID_W)
) u_chk (.*);

// File: tb/tb_xlat_cache.sv
`timescale 1ns/1ps
module tb_xlat_cache;
   localparam int N = 8;
   localparam int VW = 20;
   localparam int FW = 20;
   localparam int PW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lk_valid = 0, walk_done = 0, walk_ok = 0, flush_all = 0, flush_one = 0;
   logic [VW-1:0] lk_vpn = '0;
   logic [PW-1:0] lk_pid = '0, flush_pid = '0;
   logic [FW-1:0] walk_pfn = '0;
   logic lk_ready, lk_hit, lk_fault, walk_req;
   logic [FW-1:0] lk_pfn;
   logic [VW-1:0] walk_vpn;
   logic [PW-1:0] walk_pid;

   int checks = 0;
   int failures = 0;

   always #4 clk = ~clk;

   xlat_cache #(.ENTRIES(N), .VPN_W(VW), .PFN_W(FW), .PID_W(PW)) dut (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_pid(lk_pid),
      .lk_ready(lk_ready), .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_fault(lk_fault),
      .walk_req(walk_req), .walk_vpn(walk_vpn), .walk_pid(walk_pid),
      .walk_done(walk_done), .walk_ok(walk_ok), .walk_pfn(walk_pfn),
      .flush_all(flush_all), .flush_one(flush_one), .flush_pid(flush_pid));

   // Behavioural reference model
   bit            m_v [N];
   int            m_vpn [N];
   int            m_pid [N];
   int            m_pfn [N];
   int            m_rr;
   bit            m_walk;
   int            m_pv, m_pp;

   function automatic int m_find(int vpn, int pid);
      for (int i = 0; i < N; i++)
         if (m_v[i] && m_vpn[i] == vpn && m_pid[i] == pid) return i;
      return -1;
   endfunction

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) m_v[i] = 0;
         m_rr = 0; m_walk = 0; m_pv = 0; m_pp = 0;
      end else begin
         automatic int  slot = -1;
         automatic bit  fill = 0;
         automatic bit  full = 1;
         for (int i = N - 1; i >= 0; i--) if (!m_v[i]) begin slot = i; full = 0; end
         if (full) slot = m_rr;
         if (!m_walk) begin
            if (lk_valid && m_find(int'(lk_vpn), int'(lk_pid)) < 0) begin
               m_walk = 1; m_pv = int'(lk_vpn); m_pp = int'(lk_pid);
            end
         end else if (walk_done) begin
            m_walk = 0;
            fill = walk_ok && !flush_all && !(flush_one && int'(flush_pid) == m_pp);
         end
         for (int i = 0; i < N; i++)
            if (flush_all || (flush_one && m_pid[i] == int'(flush_pid))) m_v[i] = 0;
         if (fill) begin
            m_v[slot] = 1; m_vpn[slot] = m_pv; m_pid[slot] = m_pp; m_pfn[slot] = int'(walk_pfn);
            if (full) m_rr = (m_rr + 1) % N;
         end
      end
   end

   // Every-cycle comparison against the model, away from the clock edge
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         automatic int  h = m_find(int'(lk_vpn), int'(lk_pid));
         automatic bit  eh = lk_valid && !m_walk && h >= 0;
         chk(lk_ready == !m_walk, "R3", "model lk_ready", lk_ready, !m_walk);
         chk(walk_req == m_walk, "R3", "model walk_req", walk_req, m_walk);
         chk(lk_hit == eh, "R1", "model lk_hit", lk_hit, eh);
         if (eh) chk(int'(lk_pfn) == m_pfn[h], "R1", "model lk_pfn", lk_pfn, m_pfn[h]);
         chk(lk_fault == (m_walk && walk_done && !walk_ok), "R5", "model lk_fault",
             lk_fault, m_walk && walk_done && !walk_ok);
         if (m_walk) begin
            chk(int'(walk_vpn) == m_pv && int'(walk_pid) == m_pp, "R3", "model walk_vpn",
                walk_vpn, m_pv);
         end
      end
   end

   task automatic clr();
      lk_valid = 0; walk_done = 0; walk_ok = 0; flush_all = 0; flush_one = 0;
   endtask

   task automatic lookup(int vpn, int pid, bit exp_hit, int exp_pfn, string req);
      @(negedge clk); clr();
      lk_valid = 1; lk_vpn = VW'(vpn); lk_pid = PW'(pid);
      #2;
      chk(lk_hit == exp_hit, req, "lk_hit", lk_hit, exp_hit);
      if (exp_hit) chk(int'(lk_pfn) == exp_pfn, req, "lk_pfn", lk_pfn, exp_pfn);
   endtask

   task automatic walk_resp(bit ok, int pfn, bit fa, bit fo, int fpid, string req);
      repeat (2) begin
         @(negedge clk); clr();
         #2 chk(lk_ready == 0 && walk_req == 1, "R3", "stall during walk", lk_ready, 0);
      end
      @(negedge clk); clr();
      walk_done = 1; walk_ok = ok; walk_pfn = FW'(pfn);
      flush_all = fa; flush_one = fo; flush_pid = PW'(fpid);
      #2 chk(lk_fault == !ok, req, "lk_fault at walk end", lk_fault, !ok);
      @(negedge clk); clr();
      #2 chk(lk_ready == 1 && lk_fault == 0, req, "ready after walk", lk_ready, 1);
   endtask

   task automatic refill(int vpn, int pid, int pfn, string req);
      lookup(vpn, pid, 0, 0, req);
      walk_resp(1, pfn, 0, 0, 0, req);
      lookup(vpn, pid, 1, pfn, "R4");
   endtask

   task automatic probe_miss(int vpn, int pid, string req);
      lookup(vpn, pid, 0, 0, req);
      walk_resp(0, 0, 0, 0, 0, "R5");
   endtask

   task automatic do_flush(bit fa, bit fo, int fpid);
      @(negedge clk); clr();
      flush_all = fa; flush_one = fo; flush_pid = PW'(fpid);
   endtask

   initial begin
      #(8 * 200000);
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      #2;
      chk(lk_ready == 1, "R11", "reset lk_ready", lk_ready, 1);
      chk(walk_req == 0 && lk_fault == 0, "R11", "reset walk_req", walk_req, 0);
      lookup('h100, 1, 0, 0, "R11");
      walk_resp(1, 'h500, 0, 0, 0, "R4");
      lookup('h100, 1, 1, 'h500, "R4");
      for (int p = 1; p < N; p++) refill('h100 + p, 1, 'h500 + p, "R6");
      // same page, other process
      probe_miss('h100, 2, "R2");
      probe_miss('h100, 2, "R5");
      lookup('h100, 1, 1, 'h500, "R2");
      // full: round-robin from slot 0
      refill('h200, 1, 'h600, "R7");
      probe_miss('h100, 1, "R7");
      refill('h201, 1, 'h601, "R7");
      probe_miss('h101, 1, "R7");
      lookup('h102, 1, 1, 'h502, "R7");
      // per-process flush of an absent process
      do_flush(0, 1, 3);
      lookup('h102, 1, 1, 'h502, "R9");
      refill('h400, 3, 'h900, "R7");
      probe_miss('h102, 1, "R7");
      do_flush(0, 1, 3);
      probe_miss('h400, 3, "R9");
      lookup('h103, 1, 1, 'h503, "R9");
      lookup('h200, 1, 1, 'h600, "R9");
      // freed slot reused first, pointer unchanged
      refill('h300, 1, 'h700, "R6");
      lookup('h103, 1, 1, 'h503, "R6");
      refill('h301, 1, 'h701, "R6");
      probe_miss('h103, 1, "R6");
      lookup('h104, 1, 1, 'h504, "R6");
      // refill colliding with flush of its process
      lookup('h600, 1, 0, 0, "R10");
      walk_resp(1, 'h800, 0, 1, 1, "R10");
      probe_miss('h600, 1, "R10");
      probe_miss('h104, 1, "R9");
      // full flush
      refill('h700, 5, 'hA00, "R4");
      refill('h701, 6, 'hA01, "R4");
      do_flush(1, 0, 0);
      @(negedge clk); clr();
      probe_miss('h700, 5, "R8");
      probe_miss('h701, 6, "R8");
      lookup('h710, 7, 0, 0, "R10");
      walk_resp(1, 'hB00, 1, 0, 0, "R10");
      probe_miss('h710, 7, "R10");
      @(negedge clk); clr();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule